// File: doc/BRIEF.md
# Operand Address Generator

This block turns an addressing-mode code, the operand bytes that follow an opcode, and the two index registers into the 16-bit address that an 8-bit processor's execute stage will use. It also reports how far the program counter must move past the instruction (one, two or three bytes) and whether an indexed sum left the page of its base address, so that the caller can charge a penalty cycle.

Modes that need no memory access finish one cycle after the request. Modes that go through a pointer hold the request, read the pointer low byte and then the high byte over a synchronous read port, and finish one cycle after the high byte returns. Zero-page forms wrap inside page zero, both for the indexed sum and for the second pointer byte. Absolute-indexed and pointer-plus-Y sums carry into the high byte and flag the crossing.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `page_cross` and `mem_rd_en` are 0, and `ea` and `pc_step` are 0.
- R2: Mode codes are 0 none (accumulator), 1 immediate, 2 zero page, 3 zero page plus X, 4 zero page plus Y, 5 absolute, 6 absolute plus X, 7 absolute plus Y, 8 pre-indexed pointer, 9 post-indexed pointer, 10 absolute pointer; `pc_step` is 1 for code 0, 2 for codes 1 to 4, 8 and 9, and 3 for codes 5, 6, 7 and 10. Codes 11 to 15 behave as code 0.
- R3: Code 0 gives `ea` = 0; code 1 gives `ea` = `pc` + 1 (modulo 2^16), `pc` being the opcode address.
- R4: Code 2 gives `ea` = {0x00, lo}; codes 3 and 4 give {0x00, (lo + X) mod 256} and {0x00, (lo + Y) mod 256}.
- R5: Code 5 gives `ea` = {hi, lo}; codes 6 and 7 give {hi, lo} + X and {hi, lo} + Y with full 16-bit carry.
- R6: `page_cross` is 1 only for codes 6, 7 and 9, and then exactly when the high byte of the result differs from the high byte of the unindexed base.
- R7: Code 8 reads the pointer low byte at {0x00, (lo + X) mod 256} and the high byte at the next zero-page address modulo 256; `ea` is that pointer.
- R8: Code 9 reads the pointer low byte at {0x00, lo} and the high byte at {0x00, (lo + 1) mod 256}; `ea` is the pointer plus Y with full 16-bit carry.
- R9: Code 10 reads the pointer low byte at {hi, lo} and the high byte at {hi, lo} + 1 (16-bit); `ea` is that pointer.
- R10: A request with a direct code (0 to 7, 11 to 15) yields `done` in the cycle after the accepting edge; a pointer code asserts `mem_rd_en` for the low byte, then for the high byte in the next cycle, and yields `done` one cycle after the high byte is returned (the fourth cycle after the accepting edge).
- R11: `done` is a one-cycle pulse per accepted request; a `req` raised while a pointer fetch is in progress is ignored and leaves the outputs of the pending request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an address computation |
| mode | input | 4 | Addressing-mode code (see R2) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the opcode |
| mem_rd_en | output | 1 | Pointer read strobe |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| ea | output | 16 | Effective address, held until the next result |
| pc_step | output | 2 | Bytes to advance the program counter |
| page_cross | output | 1 | Indexed sum changed page |
| done | output | 1 | Result valid pulse |

## Verification
Direct-mode results land in the registers at the edge that accepts the request, so the bench looks for `done` at the first falling edge after it; pointer-mode results need the low-byte read, the high-byte read and the data return, so `done` is due at the fourth falling edge. The bench counts falling edges from the request to `done` and compares that count with 1 or 4 per mode, then compares `ea`, `pc_step` and `page_cross` in that same sample. Pointer contents come from a memory whose bytes are a computed function of the address, so every expected pointer is derived from the address alone.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam logic [3:0] AM_NONE = 4'd0;
  localparam logic [3:0] AM_IMM  = 4'd1;
  localparam logic [3:0] AM_ZP   = 4'd2;
  localparam logic [3:0] AM_ZPX  = 4'd3;
  localparam logic [3:0] AM_ZPY  = 4'd4;
  localparam logic [3:0] AM_ABS  = 4'd5;
  localparam logic [3:0] AM_ABSX = 4'd6;
  localparam logic [3:0] AM_ABSY = 4'd7;
  localparam logic [3:0] AM_PREX = 4'd8;
  localparam logic [3:0] AM_POSY = 4'd9;
  localparam logic [3:0] AM_PTR  = 4'd10;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LO   = 2'd1,
    SQ_HI   = 2'd2,
    SQ_FIN  = 2'd3
  } seq_t;

  function automatic logic is_ptr_mode(input logic [3:0] m);
    return (m == AM_PREX) || (m == AM_POSY) || (m == AM_PTR);
  endfunction

  function automatic logic [1:0] step_of(input logic [3:0] m);
    case (m)
      AM_IMM, AM_ZP, AM_ZPX, AM_ZPY, AM_PREX, AM_POSY: return 2'd2;
      AM_ABS, AM_ABSX, AM_ABSY, AM_PTR:                return 2'd3;
      default:                                         return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int unsigned DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  input  logic            zp_wrap,
  output logic [2*DW-1:0] sum,
  output logic            crossed
);
  localparam int unsigned AW = 2 * DW;

  logic [AW-1:0] full_sum;
  logic [DW-1:0] low_sum;

  always_comb begin
    full_sum = base + {{DW{1'b0}}, idx};
    low_sum  = base[DW-1:0] + idx;
    if (zp_wrap) begin
      sum     = {{DW{1'b0}}, low_sum};
      crossed = 1'b0;
    end else begin
      sum     = full_sum;
      crossed = (full_sum[AW-1:DW] != base[AW-1:DW]);
    end
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ptr_mode,
  output seq_t state
);
  seq_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      SQ_IDLE: if (start && ptr_mode) state_d = SQ_LO;
      SQ_LO:   state_d = SQ_HI;
      SQ_HI:   state_d = SQ_FIN;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_d;
  end

  // R10
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LO) |=> (state == SQ_HI));

  // R10
  hi_then_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_HI) |=> (state == SQ_FIN));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [3:0]        mode,
  input  logic [DW-1:0]     opnd_lo,
  input  logic [DW-1:0]     opnd_hi,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  input  logic [2*DW-1:0]   pc,
  output logic              mem_rd_en,
  output logic [2*DW-1:0]   mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic [2*DW-1:0]   ea,
  output logic [1:0]        pc_step,
  output logic              page_cross,
  output logic              done
);
  localparam int unsigned AW = 2 * DW;
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [DW-1:0] BYTE_ONE = DW'(1);

  seq_t st;
  logic idle, accept, ptr_req, out_load;

  // registered request context
  logic [3:0]    mode_q;
  logic [DW-1:0] y_q, lo_byte_q;
  logic [AW-1:0] lo_addr_q, hi_addr_q;
  logic [AW-1:0] ea_q;
  logic [1:0]    step_q;
  logic          cross_q, done_q;

  // next-state values
  logic [AW-1:0] lo_addr_d, hi_addr_d;
  logic [DW-1:0] zp_ptr;
  logic [AW-1:0] dir_base, add_base, add_sum;
  logic [DW-1:0] dir_idx, add_idx;
  logic          dir_wrap, add_wrap, add_cross;
  logic [3:0]    mode_sel;

  ea_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (req),
    .ptr_mode (is_ptr_mode(mode)),
    .state    (st)
  );

  assign idle    = (st == SQ_IDLE);
  assign accept  = req && idle;
  assign ptr_req = accept && is_ptr_mode(mode);

  // direct operand formation
  always_comb begin
    dir_base = '0;
    dir_idx  = '0;
    dir_wrap = 1'b0;
    case (mode)
      AM_IMM:  dir_base = pc + ADDR_ONE;
      AM_ZP:   begin dir_base = {{DW{1'b0}}, opnd_lo}; dir_wrap = 1'b1; end
      AM_ZPX:  begin dir_base = {{DW{1'b0}}, opnd_lo}; dir_idx = idx_x; dir_wrap = 1'b1; end
      AM_ZPY:  begin dir_base = {{DW{1'b0}}, opnd_lo}; dir_idx = idx_y; dir_wrap = 1'b1; end
      AM_ABS:  dir_base = {opnd_hi, opnd_lo};
      AM_ABSX: begin dir_base = {opnd_hi, opnd_lo}; dir_idx = idx_x; end
      AM_ABSY: begin dir_base = {opnd_hi, opnd_lo}; dir_idx = idx_y; end
      default: dir_base = '0;
    endcase
  end

  // shared adder: direct operands when idle, fetched pointer at finish
  always_comb begin
    if (idle) begin
      add_base = dir_base;
      add_idx  = dir_idx;
      add_wrap = dir_wrap;
    end else begin
      add_base = {mem_rdata, lo_byte_q};
      add_idx  = (mode_q == AM_POSY) ? y_q : '0;
      add_wrap = 1'b0;
    end
  end

  ea_index_add #(.DW(DW)) u_add (
    .base    (add_base),
    .idx     (add_idx),
    .zp_wrap (add_wrap),
    .sum     (add_sum),
    .crossed (add_cross)
  );

  // pointer byte addresses
  always_comb begin
    zp_ptr = opnd_lo + ((mode == AM_PREX) ? idx_x : '0);
    if (mode == AM_PTR) begin
      lo_addr_d = {opnd_hi, opnd_lo};
      hi_addr_d = {opnd_hi, opnd_lo} + ADDR_ONE;
    end else begin
      lo_addr_d = {{DW{1'b0}}, zp_ptr};
      hi_addr_d = {{DW{1'b0}}, zp_ptr + BYTE_ONE};
    end
  end

  assign mode_sel  = idle ? mode : mode_q;
  assign out_load  = (accept && !is_ptr_mode(mode)) || (st == SQ_FIN);
  assign mem_rd_en = (st == SQ_LO) || (st == SQ_HI);
  assign mem_addr  = (st == SQ_HI) ? hi_addr_q : lo_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      y_q       <= '0;
      lo_addr_q <= '0;
      hi_addr_q <= '0;
      lo_byte_q <= '0;
      ea_q      <= '0;
      step_q    <= '0;
      cross_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= out_load;
      if (accept) begin
        mode_q <= mode;
        y_q    <= idx_y;
      end
      if (ptr_req) begin
        lo_addr_q <= lo_addr_d;
        hi_addr_q <= hi_addr_d;
      end
      if (st == SQ_HI) begin
        lo_byte_q <= mem_rdata;
      end
      if (out_load) begin
        ea_q    <= add_sum;
        step_q  <= step_of(mode_sel);
        cross_q <= add_cross;
      end
    end
  end

  assign ea         = ea_q;
  assign pc_step    = step_q;
  assign page_cross = cross_q;
  assign done       = done_q;

  // R4
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (ea[AW-1:DW] == '0));

  // R6
  cross_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_cross)
      |-> (mode_q == AM_ABSX || mode_q == AM_ABSY || mode_q == AM_POSY));

  // R7
  zp_ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && (mode_q == AM_PREX || mode_q == AM_POSY))
      |-> (mem_addr[AW-1:DW] == '0));

  // R10
  ptr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_ptr_mode(mode_q)) |-> ($past(mem_rd_en, 2) && !$past(mem_rd_en, 1)));

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_step != 2'd0));

  // R11
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_rd_en);
endmodule

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
  logic        clk, rst_n, req;
  logic [3:0]  mode;
  logic [7:0]  opnd_lo, opnd_hi, idx_x, idx_y, mem_rdata;
  logic [15:0] pc, mem_addr, ea;
  logic        mem_rd_en, page_cross, done;
  logic [1:0]  pc_step;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .pc(pc), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ea(ea), .pc_step(pc_step), .page_cross(page_cross), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mf(mem_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd1:             return "R3 imm";
      4'd2, 4'd3, 4'd4: return "R4 zp";
      4'd5, 4'd6, 4'd7: return "R5 abs";
      4'd8:             return "R7 prex";
      4'd9:             return "R8 posy";
      4'd10:            return "R9 ptr";
      default:          return "R3 none";
    endcase
  endfunction

  task automatic model(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                       input logic [15:0] p, output logic [15:0] e,
                       output logic [1:0] s, output bit c, output int lat);
    logic [7:0]  z;
    logic [15:0] ptr, a;
    c = 0; lat = 1;
    case (m)
      4'd1: begin e = p + 16'd1; s = 2; end
      4'd2: begin e = {8'h00, lo}; s = 2; end
      4'd3: begin z = lo + x; e = {8'h00, z}; s = 2; end
      4'd4: begin z = lo + y; e = {8'h00, z}; s = 2; end
      4'd5: begin e = {hi, lo}; s = 3; end
      4'd6: begin e = {hi, lo} + {8'h00, x}; c = (e[15:8] != hi); s = 3; end
      4'd7: begin e = {hi, lo} + {8'h00, y}; c = (e[15:8] != hi); s = 3; end
      4'd8: begin
        z = lo + x;
        e = {mf({8'h00, z + 8'd1}), mf({8'h00, z})}; s = 2; lat = 4;
      end
      4'd9: begin
        z = lo + 8'd1;
        ptr = {mf({8'h00, z}), mf({8'h00, lo})};
        e = ptr + {8'h00, y}; c = (e[15:8] != ptr[15:8]); s = 2; lat = 4;
      end
      4'd10: begin
        a = {hi, lo};
        e = {mf(a + 16'd1), mf(a)}; s = 3; lat = 4;
      end
      default: begin e = 16'h0000; s = 1; end
    endcase
  endtask

  task automatic run_one(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                         input logic [15:0] p);
    logic [15:0] e; logic [1:0] s; bit c; int lat, got;
    model(m, lo, hi, x, y, p, e, s, c, lat);
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p; req = 1'b1;
    got = 0;
    while (got < 8) begin
      @(negedge clk);
      req = 1'b0;
      got++;
      if (done) break;
    end
    chk(got == lat, "R10 latency", got, lat);
    chk(ea == e, tag_of(m), int'(ea), int'(e));
    chk(pc_step == s, "R2 step", int'(pc_step), int'(s));
    chk(page_cross == c, "R6 cross", int'(page_cross), int'(c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] xv;
    int dn;
    rst_n = 1'b0; req = 1'b0; mode = '0; opnd_lo = '0; opnd_hi = '0;
    idx_x = '0; idx_y = '0; pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(ea == 16'h0, "R1 ea", int'(ea), 0);
    chk(pc_step == 2'd0, "R1 step", int'(pc_step), 0);
    chk(page_cross == 1'b0, "R1 cross", int'(page_cross), 0);
    chk(mem_rd_en == 1'b0, "R1 rd_en", int'(mem_rd_en), 0);

    // sweep: all codes, operand bytes, index values, high bytes
    for (int m = 0; m < 16; m++)
      for (int hsel = 0; hsel < 3; hsel++)
        for (int k = 0; k < 4; k++)
          for (int i = 0; i < 16; i++) begin
            logic [7:0] hv;
            hv = (hsel == 0) ? 8'h00 : (hsel == 1) ? 8'h7F : 8'hFF;
            case (k)
              0: xv = 8'h00;
              1: xv = 8'h01;
              2: xv = 8'h7F;
              default: xv = 8'hFF;
            endcase
            run_one(4'(m), 8'(i * 17), hv, xv, xv ^ 8'h81, {hv, 8'(i * 17)});
          end

    // R11: request during a pointer fetch is ignored, one done pulse
    begin
      logic [15:0] e; logic [1:0] s; bit c; int lat;
      model(4'd9, 8'hF0, 8'h00, 8'h00, 8'hC3, 16'h0, e, s, c, lat);
      @(negedge clk);
      mode = 4'd9; opnd_lo = 8'hF0; opnd_hi = 8'h00; idx_x = 8'h00; idx_y = 8'hC3;
      req = 1'b1;
      @(negedge clk);
      mode = 4'd5; opnd_lo = 8'h11; opnd_hi = 8'h22; idx_y = 8'h00;
      dn = 0;
      for (int t = 0; t < 3; t++) begin
        if (done) dn++;
        @(negedge clk);
      end
      req = 1'b0;
      for (int t = 0; t < 5; t++) begin
        if (done) dn++;
        @(negedge clk);
      end
      chk(dn == 1, "R11 one done", dn, 1);
      chk(ea == e, "R11 ea kept", int'(ea), int'(e));
      chk(page_cross == c, "R11 cross kept", int'(page_cross), int'(c));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule